// File: doc/BRIEF.md
# Paired Simultaneous-Sample Conversion Sequencer

This block is the digital control for a converter front end with two sample-and-hold circuits and sixteen start-of-conversion slots. Each slot has a trigger input and a channel-select field. Slots are grouped in even/odd pairs, and each pair has one coupling enable. In uncoupled (sequential) operation, a trigger runs one sample and one conversion for that slot alone. In coupled operation, a trigger on either slot of the pair makes both sample-and-hold circuits capture the A and B inputs of one channel index at the same instant. The block then runs two conversions back to back, A first and then B.

The converter is external. The sequencer issues a one-cycle sample strobe and then holds a conversion request until the converter returns a one-cycle done pulse with a 12-bit result. Results land in one register per slot, and a one-hot end-of-conversion (EOC) pulse marks each conversion. One global setting moves every EOC pulse to either the start or the end of its conversion.

Triggers are latched as pending per slot and served lowest index first. A trigger that arrives on a slot that is already pending sets a sticky overflow flag for that slot.

Top module: `pair_conv_seq`

## Requirements
- R1: After reset, all result registers, EOC outputs, overflow flags, the sample strobe and the conversion request are 0.
- R2: An uncoupled slot trigger gives one sample strobe and then one conversion. Select bit 3 picks the side (0 = A, 1 = B) and bits 2:0 pick the input index. The result goes to that slot's register, and that slot's EOC bit pulses. The request stays high until done.
- R3: In coupled mode, a trigger on either the even or the odd slot of a pair gives exactly one sample strobe, followed by an A conversion and then a B conversion. The strobe is followed directly by the request.
- R4: In coupled mode, the A result is written to the even slot's register with an EOC on the even bit, and the B result is written to the odd slot's register with an EOC on the odd bit. At most one EOC bit is high in any cycle.
- R5: In coupled mode, bit 3 of the triggered slot's select field is ignored, so values 8 to 15 convert the pair with index value minus 8.
- R6: If both slots of a coupled pair are triggered, two complete pairs run, the even slot's first. The second pair overwrites both registers.
- R7: Pending slots are served lowest index first.
- R8: A trigger on a slot that is already pending, and is not being granted in that cycle, sets that slot's overflow bit. The bit stays set until reset, and other slots' bits are unaffected.
- R9: With pulse-at-start = 0, each EOC pulse comes in the cycle after done, with the new result already visible. With pulse-at-start = 1, each EOC pulse comes in the first cycle of its conversion's request.
- R10: The sample strobe and the conversion request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 16 | Per-slot trigger pulses |
| pair_en | input | 8 | Coupling enable per even/odd slot pair |
| chan_sel | input | 64 | Per-slot 4-bit channel select, slot k in bits 4k+3:4k |
| eoc_at_start | input | 1 | 1: EOC at conversion start, 0: EOC after done |
| smp_strobe | output | 1 | One-cycle sample command |
| smp_chan | output | 3 | Input index being sampled |
| conv_req | output | 1 | Conversion request, held until done |
| conv_side | output | 1 | Side converted (0 = A, 1 = B) |
| conv_chan | output | 3 | Input index converted |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Converter result, valid with done |
| result | output | 192 | Result registers, slot k in bits 12k+11:12k |
| eoc | output | 16 | One-hot end-of-conversion pulses |
| ovf | output | 16 | Sticky per-slot trigger overflow flags |

## Verification
The hardest case to reach is a second trigger landing on a slot that is still pending. The block must also grant a different slot in that same cycle. The stimulus fires two slots together and then retriggers the higher one on the next cycle, while the lower one is being granted. The double-coupled case is reached in a similar way: both slots of a pair are triggered in the same cycle, and the even slot's select field is valid while the odd slot's uses a value of 8 or above. This checks the clamp, the ordering and the overwrite in one run. The converter model tags each result with a per-strobe sample count, so the bench can check that one strobe serves both halves of a pair.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/pcs_pending.sv
module pcs_pending #(
   parameter int N_SLOT = 16,
   localparam int IDX_W = $clog2(N_SLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SLOT-1:0] trig,
   input  logic              clr_vld,
   input  logic [IDX_W-1:0]  clr_idx,
   output logic [N_SLOT-1:0] pend,
   output logic [N_SLOT-1:0] ovf
);
   generate
      if (N_SLOT < 2) begin : g_bad_n
         $error("pcs_pending: N_SLOT must be at least 2");
      end
   endgenerate

   for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
      logic clr_here;
      assign clr_here = clr_vld && (clr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            ovf[i]  <= 1'b0;
         end else begin
            pend[i] <= trig[i] | (pend[i] & ~clr_here);
            ovf[i]  <= ovf[i] | (trig[i] & pend[i] & ~clr_here);
         end
      end

      // R8
      ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[i] && pend[i] && !clr_here) |=> ovf[i]);
      // R8
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ovf[i] |=> ovf[i]);
   end
endmodule

// File: rtl/pcs_arbiter.sv
module pcs_arbiter #(
   parameter int N_SLOT = 16,
   localparam int IDX_W = $clog2(N_SLOT)
) (
   input  logic [N_SLOT-1:0] pend,
   output logic              gnt_vld,
   output logic [IDX_W-1:0]  gnt_idx
);
   always_comb begin
      gnt_idx = '0;
      for (int i = N_SLOT - 1; i >= 0; i--) begin
         if (pend[i]) gnt_idx = IDX_W'(i);
      end
   end

   assign gnt_vld = |pend;
endmodule

// File: rtl/pcs_result_bank.sv
module pcs_result_bank #(
   parameter int N_SLOT = 16,
   parameter int DATA_W = 12,
   localparam int IDX_W = $clog2(N_SLOT)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     eoc_set,
   input  logic [IDX_W-1:0]         eoc_idx,
   output logic [N_SLOT*DATA_W-1:0] result,
   output logic [N_SLOT-1:0]        eoc
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("pcs_result_bank: DATA_W must be positive");
      end
   endgenerate

   for (genvar i = 0; i < N_SLOT; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            result[i*DATA_W +: DATA_W] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            result[i*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoc <= '0;
      end else begin
         eoc <= eoc_set ? ({{(N_SLOT-1){1'b0}}, 1'b1} << eoc_idx) : '0;
      end
   end

   // R4
   eoc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoc));
endmodule

// File: rtl/pair_conv_seq.sv
module pair_conv_seq #(
   parameter int N_SLOT = 16,
   parameter int SEL_W  = 4,
   parameter int DATA_W = 12,
   localparam int N_PAIR = N_SLOT / 2,
   localparam int IDX_W  = $clog2(N_SLOT),
   localparam int IN_W   = SEL_W - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SLOT-1:0]        trig,
   input  logic [N_PAIR-1:0]        pair_en,
   input  logic [N_SLOT*SEL_W-1:0]  chan_sel,
   input  logic                     eoc_at_start,
   output logic                     smp_strobe,
   output logic [IN_W-1:0]          smp_chan,
   output logic                     conv_req,
   output logic                     conv_side,
   output logic [IN_W-1:0]          conv_chan,
   input  logic                     conv_done,
   input  logic [DATA_W-1:0]        conv_data,
   output logic [N_SLOT*DATA_W-1:0] result,
   output logic [N_SLOT-1:0]        eoc,
   output logic [N_SLOT-1:0]        ovf
);
   import pcs_pkg::*;

   generate
      if ((N_SLOT % 2) != 0) begin : g_bad_pairs
         $error("pair_conv_seq: N_SLOT must be even");
      end
      if (SEL_W < 2) begin : g_bad_sel
         $error("pair_conv_seq: SEL_W must be at least 2");
      end
   endgenerate

   seq_state_t       state;
   logic [IDX_W-1:0] cur_slot;
   logic             cur_cpl;
   logic [IN_W-1:0]  cur_chan;
   logic             phase;

   logic [N_SLOT-1:0] pend;
   logic              gnt_vld;
   logic [IDX_W-1:0]  gnt_idx;
   logic              take;
   logic [SEL_W-1:0]  gnt_sel;
   logic              gnt_cpl;

   assign take    = (state == ST_IDLE) && gnt_vld;
   assign gnt_sel = chan_sel[gnt_idx*SEL_W +: SEL_W];
   assign gnt_cpl = pair_en[gnt_idx[IDX_W-1:1]];

   pcs_pending #(.N_SLOT(N_SLOT)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig),
      .clr_vld (take),
      .clr_idx (gnt_idx),
      .pend    (pend),
      .ovf     (ovf)
   );

   pcs_arbiter #(.N_SLOT(N_SLOT)) u_arb (
      .pend    (pend),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx)
   );

   logic finish_cv;
   logic chain_b;
   assign finish_cv = (state == ST_CONV) && conv_done;
   assign chain_b   = finish_cv && cur_cpl && !phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_slot <= '0;
         cur_cpl  <= 1'b0;
         cur_chan <= '0;
         phase    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (gnt_vld) begin
                  cur_slot <= gnt_idx;
                  cur_cpl  <= gnt_cpl;
                  cur_chan <= gnt_sel[IN_W-1:0];
                  phase    <= gnt_cpl ? 1'b0 : gnt_sel[SEL_W-1];
                  state    <= ST_SAMPLE;
               end
            end
            ST_SAMPLE: state <= ST_CONV;
            ST_CONV: begin
               if (chain_b)        phase <= 1'b1;
               else if (conv_done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign smp_strobe = (state == ST_SAMPLE);
   assign smp_chan   = cur_chan;
   assign conv_req   = (state == ST_CONV);
   assign conv_side  = phase;
   assign conv_chan  = cur_chan;

   logic [IDX_W-1:0] tgt_slot;
   logic [IDX_W-1:0] b_slot;
   logic             start_evt;
   logic [IDX_W-1:0] start_idx;

   assign tgt_slot  = cur_cpl ? {cur_slot[IDX_W-1:1], phase} : cur_slot;
   assign b_slot    = {cur_slot[IDX_W-1:1], 1'b1};
   assign start_evt = smp_strobe || chain_b;
   assign start_idx = chain_b ? b_slot : tgt_slot;

   pcs_result_bank #(.N_SLOT(N_SLOT), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (finish_cv),
      .wr_idx  (tgt_slot),
      .wr_data (conv_data),
      .eoc_set (eoc_at_start ? start_evt : finish_cv),
      .eoc_idx (eoc_at_start ? start_idx : tgt_slot),
      .result  (result),
      .eoc     (eoc)
   );

   // R10
   strobe_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_strobe && conv_req));
   // R3
   strobe_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe |=> (conv_req && !smp_strobe));
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> conv_req);
   // R9
   eoc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_done && !eoc_at_start) |=> (eoc != '0));
endmodule

// File: tb/pair_conv_seq_tb.sv
module pair_conv_seq_tb;
   localparam int N  = 16;
   localparam int SW = 4;
   localparam int DW = 12;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  trig = '0;
   logic [N/2-1:0] pair_en = '0;
   logic [N*SW-1:0] chan_sel = '0;
   logic          eoc_at_start = 1'b0;
   logic          smp_strobe;
   logic [2:0]    smp_chan;
   logic          conv_req;
   logic          conv_side;
   logic [2:0]    conv_chan;
   logic          conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [N*DW-1:0] result;
   logic [N-1:0]  eoc;
   logic [N-1:0]  ovf;

   always #4 clk = ~clk;

   pair_conv_seq u_dut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .pair_en(pair_en),
      .chan_sel(chan_sel), .eoc_at_start(eoc_at_start),
      .smp_strobe(smp_strobe), .smp_chan(smp_chan), .conv_req(conv_req),
      .conv_side(conv_side), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_data(conv_data), .result(result), .eoc(eoc), .ovf(ovf)
   );

   // Converter model: result = {side, index, sample count}
   int smp_cnt = 0;
   int id_lat  = 0;
   int lat_cnt = 0;
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (smp_strobe) begin
         id_lat  <= smp_cnt;
         smp_cnt <= smp_cnt + 1;
      end
      if (conv_req && !conv_done) begin
         if (lat_cnt == LAT) begin
            conv_done <= 1'b1;
            conv_data <= {conv_side, conv_chan, 8'(id_lat)};
            lat_cnt   <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   int exp_slot[$];
   logic [DW-1:0] exp_val[$];
   int exp_id = 0;

   function automatic logic [DW-1:0] mk(input bit side, input int ch, input int id);
      return {side, 3'(ch), 8'(id)};
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input int slot, input logic [DW-1:0] v);
      exp_slot.push_back(slot);
      exp_val.push_back(v);
   endtask

   task automatic fire(input logic [N-1:0] m);
      @(negedge clk) trig = m;
      @(negedge clk) trig = '0;
   endtask

   task automatic set_sel(input int slot, input int v);
      chan_sel[slot*SW +: SW] = SW'(v);
   endtask

   task automatic drain;
      for (int k = 0; k < 400 && exp_slot.size() != 0; k++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Monitor: pops one expected item per EOC pulse
   always @(negedge clk) begin
      if (rst_n && eoc != '0) begin
         n_chk++;
         if (exp_slot.size() == 0) begin
            n_bad++;
            $display("FAIL R4: actual eoc %h expected none", eoc);
         end else begin
            int s;
            logic [DW-1:0] v;
            s = exp_slot.pop_front();
            v = exp_val.pop_front();
            if (eoc !== (N'(1) << s)) begin
               n_bad++;
               $display("FAIL R7/R4: actual eoc %h expected %h", eoc, N'(1) << s);
            end else if (eoc_at_start) begin
               if (conv_req !== 1'b1) begin
                  n_bad++;
                  $display("FAIL R9: actual conv_req %b expected 1 at eoc", conv_req);
               end
            end else if (result[s*DW +: DW] !== v) begin
               n_bad++;
               $display("FAIL R2/R9: slot %0d actual %h expected %h", s, result[s*DW +: DW], v);
            end
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 result", DW'(|result), '0);
      check("R1 eoc", DW'(eoc), '0);
      check("R1 ovf", DW'(ovf), '0);
      check("R1 strobe", DW'(smp_strobe), '0);
      check("R1 req", DW'(conv_req), '0);

      // R2 sequential, side A
      set_sel(4, 3);
      push(4, mk(0, 3, exp_id)); exp_id++;
      fire(N'(1) << 4);
      drain();
      // R2 sequential, side B via bit 3
      set_sel(10, 12);
      push(10, mk(1, 4, exp_id)); exp_id++;
      fire(N'(1) << 10);
      drain();
      // R7 lowest index first
      set_sel(9, 1); set_sel(3, 6);
      push(3, mk(0, 6, exp_id)); exp_id++;
      push(9, mk(0, 1, exp_id)); exp_id++;
      fire((N'(1) << 9) | (N'(1) << 3));
      drain();
      // R3 R4 coupled, even trigger
      pair_en[0] = 1'b1; set_sel(0, 2);
      push(0, mk(0, 2, exp_id)); push(1, mk(1, 2, exp_id)); exp_id++;
      fire(N'(1) << 0);
      drain();
      // R3 coupled, odd trigger
      pair_en[3] = 1'b1; set_sel(7, 5);
      push(6, mk(0, 5, exp_id)); push(7, mk(1, 5, exp_id)); exp_id++;
      fire(N'(1) << 7);
      drain();
      // R5 R6 both slots triggered, odd select clamped (13 -> 5)
      pair_en[1] = 1'b1; set_sel(2, 5); set_sel(3, 13);
      push(2, mk(0, 5, exp_id)); push(3, mk(1, 5, exp_id)); exp_id++;
      push(2, mk(0, 5, exp_id)); push(3, mk(1, 5, exp_id)); exp_id++;
      fire((N'(1) << 2) | (N'(1) << 3));
      drain();
      check("R6 overwrite even", result[2*DW +: DW], mk(0, 5, exp_id - 1));
      check("R5 clamp odd", result[3*DW +: DW], mk(1, 5, exp_id - 1));
      check("R8 no ovf yet", DW'(ovf), '0);

      // R8 overflow: retrigger slot 5 while pending
      pair_en = '0; set_sel(0, 1); set_sel(5, 7);
      push(0, mk(0, 1, exp_id)); exp_id++;
      push(5, mk(0, 7, exp_id)); exp_id++;
      @(negedge clk) trig = (N'(1) << 0) | (N'(1) << 5);
      @(negedge clk) trig = N'(1) << 5;
      @(negedge clk) trig = '0;
      drain();
      check("R8 ovf flag", DW'(ovf), DW'(N'(1) << 5));

      // R9 pulse at start, coupled pair 2
      eoc_at_start = 1'b1; pair_en[2] = 1'b1; set_sel(4, 3);
      push(4, '0); push(5, '0);
      fire(N'(1) << 4);
      drain();
      check("R9 start-mode A result", result[4*DW +: DW], mk(0, 3, exp_id));
      check("R9 start-mode B result", result[5*DW +: DW], mk(1, 3, exp_id));
      exp_id++;
      check("R3 one strobe per pair", DW'(smp_cnt), DW'(exp_id));
      check("R4 queue empty", DW'(exp_slot.size()), '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule